// File: doc/BRIEF.md
# Transmit Endpoint Control Byte and Sequencer

This block holds the upper control byte of one USB transmit endpoint and runs the small amount of sequencing around it. Software reaches it through a byte-wide write strobe and a combinational read-back byte. The control byte selects five behaviours. One bit arms automatic packet-ready marking when a full packet has been loaded. One bit steers the endpoint direction for a FIFO that serves both directions. One bit enables a DMA request, and another picks how often that DMA path interrupts. The last sets the data toggle, either by forcing a flip or by a guarded direct load.

The block owns the transmit data-toggle bit and the packet-ready flag. It watches the FIFO byte count against the maximum packet size, and the handshake strobes from the packet engine: packet sent and ACK received. It reports a packet as finished by pulsing a FIFO flush. The same flush pulse also marks a forced discard. The FIFO memory, the packet engine and the routing of DMA channels sit outside the block. A host-mode input selects the host behaviour of the two low bits. In device mode those two bits are reserved.

Top module: `tx_ep_ctrl`

## Requirements
- R1: Read-back byte: bit 7 = auto-ready arm, bit 5 = direction, bit 4 = DMA enable, bit 2 = interrupt mode. Bits 6, 3 and 1 always read 0. Bit 0 reads the data toggle in host mode. All fields are 0 after reset. A register write updates bits 7, 5, 4 and 2 on the next clock edge.
- R2: With bit 7 set, `tx_ready` rises on the edge after the first cycle in which `fifo_count` equals `max_pkt`, when it did not equal `max_pkt` in the cycle before. A count below `max_pkt` never sets it.
- R3: With bit 7 clear, `tx_ready` is set only by `sw_ready_set`, on the following edge.
- R4: While `tx_ready` is 1, `pkt_sent` together with `ack_rcvd` completes the packet. `fifo_flush` is high in that cycle, and on the next edge the toggle flips and `tx_ready` clears. `pkt_sent` without `ack_rcvd` changes neither the toggle nor `tx_ready`.
- R5: A write with bit 3 set raises `fifo_flush` in that cycle. On the next edge it flips the toggle and clears `tx_ready`, with or without an ACK. The toggle flips only once when this coincides with a completion.
- R6: In host mode, a write with bit 1 set loads bit 0 into the toggle on the next edge, and this load overrides any flip. A write with bit 1 clear leaves the toggle unaffected by bit 0.
- R7: In device mode, written bits 1 and 0 have no effect and bit 0 reads 0. The toggle is still kept and driven on `data_toggle`.
- R8: `dir_tx` equals the stored bit 5, where 1 means transmit.
- R9: `dma_req` is high exactly while DMA is enabled and `tx_ready` is 0.
- R10: When DMA is enabled, `irq` pulses one cycle after `dma_pkt_done` if the interrupt mode is 0. It pulses one cycle after `dma_xfer_done` if the mode is 1. When DMA is disabled, `irq` stays 0.
- R11: When a set and a clear of `tx_ready` fall in the same cycle, the clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_mode | input | 1 | 1 = host behaviour of bits 1 and 0, 0 = device |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_data | input | 8 | Register write byte |
| reg_rd_data | output | 8 | Register read-back byte |
| sw_ready_set | input | 1 | Software request to mark the packet ready |
| fifo_count | input | CNT_W | Bytes currently in the transmit FIFO |
| max_pkt | input | CNT_W | Maximum packet size |
| pkt_sent | input | 1 | Packet engine finished sending a packet |
| ack_rcvd | input | 1 | ACK received for the sent packet |
| dma_pkt_done | input | 1 | DMA finished one packet |
| dma_xfer_done | input | 1 | DMA finished the whole transfer |
| tx_ready | output | 1 | Packet ready to send |
| data_toggle | output | 1 | Current transmit data toggle |
| dir_tx | output | 1 | Endpoint direction, 1 = transmit |
| fifo_flush | output | 1 | Pulse: discard the current packet from the FIFO |
| dma_req | output | 1 | DMA request for this endpoint |
| irq | output | 1 | DMA interrupt pulse |

## Verification
The assertions assume that the strobe inputs are synchronous and hold for the whole clock cycle. They also assume that `pkt_sent` can arrive in any state, including while `tx_ready` is 0. The block must then ignore it. The stimulus drives every input just after the falling edge and holds it through the next rising edge. Directed sequences cover a full-packet load, a short-packet load and a send without ACK. They also cover a forced flip coinciding with an ACK, guarded and unguarded toggle loads in both modes, and both interrupt modes. A long random phase then keeps `fifo_count` close to `max_pkt`, so that the auto-ready condition is crossed often.

// File: rtl/tx_ep_pkg.sv
package tx_ep_pkg;
    localparam int BIT_AUTO    = 7;
    localparam int BIT_RSV     = 6;
    localparam int BIT_DIR     = 5;
    localparam int BIT_DMAEN   = 4;
    localparam int BIT_FORCE   = 3;
    localparam int BIT_IRQMODE = 2;
    localparam int BIT_LOADEN  = 1;
    localparam int BIT_TGL     = 0;

    typedef enum logic {
        IRQ_PER_PKT  = 1'b0,
        IRQ_PER_XFER = 1'b1
    } irq_mode_e;

    typedef struct packed {
        logic      auto_arm;
        logic      dir_tx;
        logic      dma_en;
        irq_mode_e irq_mode;
    } ctrl_s;

    typedef struct packed {
        logic force_tgl;
        logic load_en;
        logic load_val;
    } tgl_cmd_s;

    function automatic logic [7:0] pack_readback(ctrl_s c, logic tgl, logic host);
        logic [7:0] b;
        b               = '0;
        b[BIT_AUTO]     = c.auto_arm;
        b[BIT_DIR]      = c.dir_tx;
        b[BIT_DMAEN]    = c.dma_en;
        b[BIT_IRQMODE]  = c.irq_mode;
        b[BIT_TGL]      = host & tgl;
        return b;
    endfunction
endpackage

// File: rtl/tx_ep_toggle.sv
module tx_ep_toggle
    import tx_ep_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     ack_done,
    input  tgl_cmd_s cmd,
    output logic     tgl
);
    logic flip;
    assign flip = ack_done | cmd.force_tgl;

    always_ff @(posedge clk) begin
        if (rst)              tgl <= 1'b0;
        else if (cmd.load_en) tgl <= cmd.load_val;
        else if (flip)        tgl <= ~tgl;
    end

    // R4, R5: a flip event without a load inverts the toggle
    a_r4_flip_on_event: assert property (@(posedge clk) disable iff (rst)
        (flip && !cmd.load_en) |=> (tgl != $past(tgl)));
    // R6: a guarded load wins
    a_r6_load_wins: assert property (@(posedge clk) disable iff (rst)
        cmd.load_en |=> (tgl == $past(cmd.load_val)));
    // R4: no event keeps the toggle
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!ack_done && !cmd.force_tgl && !cmd.load_en) |=> $stable(tgl));
endmodule

// File: rtl/tx_ep_ready.sv
module tx_ep_ready #(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_arm,
    input  logic             sw_set,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             clear,
    output logic             tx_ready
);
    logic full_now, full_q, auto_hit;

    assign full_now = (fifo_count == max_pkt);
    assign auto_hit = auto_arm & full_now & ~full_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            full_q   <= 1'b0;
            tx_ready <= 1'b0;
        end else begin
            full_q <= full_now;
            if (clear)                    tx_ready <= 1'b0;
            else if (sw_set || auto_hit)  tx_ready <= 1'b1;
        end
    end

    // R11: clear dominates any set
    a_r11_clear_wins: assert property (@(posedge clk) disable iff (rst)
        clear |=> !tx_ready);
    // R3: no set source, no rise
    a_r3_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!sw_set && !auto_hit) |=> !$rose(tx_ready));
    // R2: a short count with the arm set does not set the flag
    a_r2_short_no_set: assert property (@(posedge clk) disable iff (rst)
        (!sw_set && (fifo_count < max_pkt)) |=> !$rose(tx_ready));
endmodule

// File: rtl/tx_ep_dma_irq.sv
module tx_ep_dma_irq
    import tx_ep_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dma_en,
    input  irq_mode_e irq_mode,
    input  logic      tx_ready,
    input  logic      pkt_done,
    input  logic      xfer_done,
    output logic      dma_req,
    output logic      irq
);
    logic sel_evt;

    always_comb begin
        unique case (irq_mode)
            IRQ_PER_PKT:  sel_evt = pkt_done;
            IRQ_PER_XFER: sel_evt = xfer_done;
            default:      sel_evt = 1'b0;
        endcase
    end

    assign dma_req = dma_en & ~tx_ready;

    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= dma_en & sel_evt;
    end

    // R10: no interrupt while DMA is disabled
    a_r10_irq_needs_en: assert property (@(posedge clk) disable iff (rst)
        !dma_en |=> !irq);
    // R10: no strobe, no interrupt
    a_r10_irq_needs_evt: assert property (@(posedge clk) disable iff (rst)
        (!pkt_done && !xfer_done) |=> !irq);
endmodule

// File: rtl/tx_ep_ctrl.sv
module tx_ep_ctrl
    import tx_ep_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_mode,
    input  logic             reg_wr_en,
    input  logic [7:0]       reg_wr_data,
    output logic [7:0]       reg_rd_data,
    input  logic             sw_ready_set,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic [CNT_W-1:0] max_pkt,
    input  logic             pkt_sent,
    input  logic             ack_rcvd,
    input  logic             dma_pkt_done,
    input  logic             dma_xfer_done,
    output logic             tx_ready,
    output logic             data_toggle,
    output logic             dir_tx,
    output logic             fifo_flush,
    output logic             dma_req,
    output logic             irq
);
    ctrl_s    ctrl_q;
    tgl_cmd_s tcmd;
    logic     ack_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (reg_wr_en) begin
            ctrl_q.auto_arm <= reg_wr_data[BIT_AUTO];
            ctrl_q.dir_tx   <= reg_wr_data[BIT_DIR];
            ctrl_q.dma_en   <= reg_wr_data[BIT_DMAEN];
            ctrl_q.irq_mode <= irq_mode_e'(reg_wr_data[BIT_IRQMODE]);
        end
    end

    always_comb begin
        tcmd.force_tgl = reg_wr_en & reg_wr_data[BIT_FORCE];
        tcmd.load_en   = reg_wr_en & host_mode & reg_wr_data[BIT_LOADEN];
        tcmd.load_val  = reg_wr_data[BIT_TGL];
    end

    assign ack_done    = pkt_sent & ack_rcvd & tx_ready;
    assign fifo_flush  = ack_done | tcmd.force_tgl;
    assign dir_tx      = ctrl_q.dir_tx;
    assign reg_rd_data = pack_readback(ctrl_q, data_toggle, host_mode);

    tx_ep_toggle u_toggle (
        .clk      (clk),
        .rst      (rst),
        .ack_done (ack_done),
        .cmd      (tcmd),
        .tgl      (data_toggle)
    );

    tx_ep_ready #(.CNT_W(CNT_W)) u_ready (
        .clk        (clk),
        .rst        (rst),
        .auto_arm   (ctrl_q.auto_arm),
        .sw_set     (sw_ready_set),
        .fifo_count (fifo_count),
        .max_pkt    (max_pkt),
        .clear      (fifo_flush),
        .tx_ready   (tx_ready)
    );

    tx_ep_dma_irq u_dma (
        .clk       (clk),
        .rst       (rst),
        .dma_en    (ctrl_q.dma_en),
        .irq_mode  (ctrl_q.irq_mode),
        .tx_ready  (tx_ready),
        .pkt_done  (dma_pkt_done),
        .xfer_done (dma_xfer_done),
        .dma_req   (dma_req),
        .irq       (irq)
    );

    // R1: reserved and strobe-only bits read zero
    a_r1_rsv_zero: assert property (@(posedge clk) disable iff (rst)
        (reg_rd_data[BIT_RSV] == 1'b0) && (reg_rd_data[BIT_FORCE] == 1'b0)
        && (reg_rd_data[BIT_LOADEN] == 1'b0));
    // R7: device mode hides the toggle
    a_r7_dev_tgl_hidden: assert property (@(posedge clk) disable iff (rst)
        !host_mode |-> (reg_rd_data[BIT_TGL] == 1'b0));
    // R7: device-mode writes never change the toggle directly
    a_r7_dev_no_load: assert property (@(posedge clk) disable iff (rst)
        (!host_mode && !pkt_sent && !(reg_wr_en && reg_wr_data[BIT_FORCE]))
        |=> $stable(data_toggle));
    // R4: send without ACK keeps the flag
    a_r4_noack_keeps_ready: assert property (@(posedge clk) disable iff (rst)
        (tx_ready && !ack_rcvd && !(reg_wr_en && reg_wr_data[BIT_FORCE]))
        |=> tx_ready);
endmodule

// File: tb/tx_ep_ctrl_tb.sv
module tx_ep_ctrl_tb_top;
    localparam int CNT_W = 11;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic host_mode = 1'b1;
    logic reg_wr_en = 1'b0;
    logic [7:0] reg_wr_data = '0;
    logic [7:0] reg_rd_data;
    logic sw_ready_set = 1'b0;
    logic [CNT_W-1:0] fifo_count = '0;
    logic [CNT_W-1:0] max_pkt = 11'd8;
    logic pkt_sent = 1'b0, ack_rcvd = 1'b0, dma_pkt_done = 1'b0, dma_xfer_done = 1'b0;
    logic tx_ready, data_toggle, dir_tx, fifo_flush, dma_req, irq;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    // reference model state
    bit m_auto, m_dir, m_dmaen, m_mode, m_dt, m_rdy, m_fullp, m_irq;

    always #2 clk = ~clk;

    tx_ep_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .host_mode(host_mode),
        .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data), .reg_rd_data(reg_rd_data),
        .sw_ready_set(sw_ready_set), .fifo_count(fifo_count), .max_pkt(max_pkt),
        .pkt_sent(pkt_sent), .ack_rcvd(ack_rcvd),
        .dma_pkt_done(dma_pkt_done), .dma_xfer_done(dma_xfer_done),
        .tx_ready(tx_ready), .data_toggle(data_toggle), .dir_tx(dir_tx),
        .fifo_flush(fifo_flush), .dma_req(dma_req), .irq(irq)
    );

    always @(posedge clk) begin
        bit ackd, frc, full, ndt, nrdy;
        if (rst) begin
            m_auto = 0; m_dir = 0; m_dmaen = 0; m_mode = 0;
            m_dt = 0; m_rdy = 0; m_fullp = 0; m_irq = 0;
        end else begin
            ackd = pkt_sent && ack_rcvd && m_rdy;
            frc  = reg_wr_en && reg_wr_data[3];
            full = (fifo_count == max_pkt);
            ndt = m_dt;
            if (ackd || frc) ndt = !m_dt;
            if (reg_wr_en && host_mode && reg_wr_data[1]) ndt = reg_wr_data[0];
            nrdy = m_rdy;
            if (sw_ready_set || (m_auto && full && !m_fullp)) nrdy = 1;
            if (ackd || frc) nrdy = 0;
            m_irq = m_dmaen && (m_mode ? dma_xfer_done : dma_pkt_done);
            if (reg_wr_en) begin
                m_auto = reg_wr_data[7]; m_dir = reg_wr_data[5];
                m_dmaen = reg_wr_data[4]; m_mode = reg_wr_data[2];
            end
            m_dt = ndt; m_rdy = nrdy; m_fullp = full;
        end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%h expected=%h", req, cyc, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] exp_rd;
        exp_rd = {m_auto, 1'b0, m_dir, m_dmaen, 1'b0, m_mode, 1'b0, host_mode ? m_dt : 1'b0};
        chk("R1 R7 readback", reg_rd_data, exp_rd);
        chk("R2 R3 R11 tx_ready", {7'd0, tx_ready}, {7'd0, m_rdy});
        chk("R4 R5 R6 data_toggle", {7'd0, data_toggle}, {7'd0, m_dt});
        chk("R8 dir_tx", {7'd0, dir_tx}, {7'd0, m_dir});
        chk("R4 R5 fifo_flush", {7'd0, fifo_flush},
            {7'd0, (reg_wr_en && reg_wr_data[3]) || (pkt_sent && ack_rcvd && m_rdy)});
        chk("R9 dma_req", {7'd0, dma_req}, {7'd0, m_dmaen && !m_rdy});
        chk("R10 irq", {7'd0, irq}, {7'd0, m_irq});
    endtask

    task automatic step();
        @(negedge clk);
        compare();
    endtask

    task automatic wr(input logic [7:0] b);
        reg_wr_en = 1; reg_wr_data = b;
        step();
        reg_wr_en = 0; reg_wr_data = '0;
    endtask

    task automatic send(input logic ack);
        pkt_sent = 1; ack_rcvd = ack;
        step();
        pkt_sent = 0; ack_rcvd = 0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst = 0;
        // R1: reset state
        step();
        chk("R1 reset readback", reg_rd_data, 8'h00);
        chk("R9 reset dma_req", {7'd0, dma_req}, 8'h00);
        // R1 R8: reserved bit 6 written 1 reads 0; direction follows bit 5
        wr(8'h64); step();
        chk("R8 dir set", {7'd0, dir_tx}, 8'h01);
        // R2: auto-ready on full packet
        wr(8'h80);
        for (int i = 1; i <= 8; i++) begin fifo_count = CNT_W'(i); step(); end
        step();
        chk("R2 auto ready after full", {7'd0, tx_ready}, 8'h01);
        // R4: send without ACK keeps state, with ACK completes
        send(1'b0); step();
        chk("R4 no ack keeps ready", {7'd0, tx_ready}, 8'h01);
        send(1'b1); fifo_count = '0; step();
        chk("R4 ack clears ready", {7'd0, tx_ready}, 8'h00);
        chk("R4 ack flips toggle", {7'd0, data_toggle}, 8'h01);
        // R2 R3: short packet with arm set needs software
        for (int i = 1; i <= 5; i++) begin fifo_count = CNT_W'(i); step(); end
        chk("R2 short no set", {7'd0, tx_ready}, 8'h00);
        sw_ready_set = 1; step(); sw_ready_set = 0; step();
        chk("R3 sw set", {7'd0, tx_ready}, 8'h01);
        // R5: force flip and flush without ACK
        wr(8'h88); fifo_count = '0; step();
        chk("R5 force clears ready", {7'd0, tx_ready}, 8'h00);
        chk("R5 force flips toggle", {7'd0, data_toggle}, 8'h00);
        // R5: force together with an ACK flips once
        sw_ready_set = 1; step(); sw_ready_set = 0;
        pkt_sent = 1; ack_rcvd = 1; reg_wr_en = 1; reg_wr_data = 8'h08; step();
        pkt_sent = 0; ack_rcvd = 0; reg_wr_en = 0; reg_wr_data = '0; step();
        chk("R5 single flip", {7'd0, data_toggle}, 8'h01);
        // R6: guarded loads in host mode
        wr(8'h01); step();
        chk("R6 unguarded ignored", {7'd0, data_toggle}, 8'h01);
        wr(8'h02); step();
        chk("R6 guarded load 0", {7'd0, data_toggle}, 8'h00);
        wr(8'h0B); step();
        chk("R6 load beats force", {7'd0, data_toggle}, 8'h01);
        // R7: device mode ignores bits 1,0
        host_mode = 0;
        wr(8'h02); step();
        chk("R7 device load ignored", {7'd0, data_toggle}, 8'h01);
        chk("R7 device bit0 reads 0", reg_rd_data, 8'h00);
        host_mode = 1;
        // R10: interrupt modes
        wr(8'h10);
        dma_pkt_done = 1; step(); dma_pkt_done = 0;
        chk("R10 per packet irq", {7'd0, irq}, 8'h01);
        dma_xfer_done = 1; step(); dma_xfer_done = 0;
        chk("R10 mode0 ignores xfer", {7'd0, irq}, 8'h00);
        wr(8'h14);
        dma_pkt_done = 1; step(); dma_pkt_done = 0;
        chk("R10 mode1 ignores pkt", {7'd0, irq}, 8'h00);
        dma_xfer_done = 1; step(); dma_xfer_done = 0;
        chk("R10 per transfer irq", {7'd0, irq}, 8'h01);
        // R11: set and clear in the same cycle
        wr(8'h00);
        sw_ready_set = 1; reg_wr_en = 1; reg_wr_data = 8'h08; step();
        sw_ready_set = 0; reg_wr_en = 0; reg_wr_data = '0;
        chk("R11 clear wins", {7'd0, tx_ready}, 8'h00);
        // random phase, model compared every cycle
        for (int n = 0; n < 4000; n++) begin
            reg_wr_en     = ($urandom % 8) == 0;
            reg_wr_data   = 8'($urandom);
            sw_ready_set  = ($urandom % 12) == 0;
            fifo_count    = CNT_W'($urandom % 10);
            pkt_sent      = ($urandom % 5) == 0;
            ack_rcvd      = ($urandom % 2) == 0;
            dma_pkt_done  = ($urandom % 6) == 0;
            dma_xfer_done = ($urandom % 9) == 0;
            if (($urandom % 50) == 0) host_mode = ~host_mode;
            step();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule